// File: doc/BRIEF.md
# Five-bit register-file-free sequencer core

This block is a very small sequential processor. Its data values and its addresses are both 5 bits wide. Programs live in a 32-entry instruction store that is filled through a write port. Working data lives in a 32-word data RAM. One instruction completes in every clock cycle.

There is no accumulator. The arithmetic unit takes either two immediates or two RAM words. It keeps its sum, its bitwise AND and its bitwise XOR in three separate latches. A value reaches RAM only through a dedicated save instruction. Control flow has three forms: an unconditional jump, a two-target fork that tests the sum latch for zero, and two exit forms that stop the core and present a 5-bit return value.

The controller has two named states:

- RUN executes instructions.
- HALT freezes everything.

There are two named transitions:

- RUN to HALT is taken when an exit instruction executes.
- HALT to RUN is taken only through synchronous reset. Reset also forces RUN from either state.

Top module: `tiny5_cpu`

## Requirements
- R1: An instruction word is 14 bits: opcode in bits [13:10], field A in bits [9:5], field B in bits [4:0]. In RUN, one instruction executes per clock, and the program counter advances by 1 modulo 32 unless the instruction redirects it.
- R2: Opcode 4'b0001 writes the immediate field A into the RAM word addressed by field B.
- R3: Opcodes 4'b0000 and 4'b1111 change nothing except advancing the program counter.
- R4: Opcodes 4'b0011 (sum), 4'b0101 (AND) and 4'b0111 (XOR) combine the two immediates A and B and latch the result in that operation's own register. The sum wraps modulo 32.
- R5: Opcodes 4'b0100 (sum), 4'b0110 (AND) and 4'b1000 (XOR) perform the same operations on RAM[A] and RAM[B].
- R6: Opcodes 4'b0010, 4'b1001 and 4'b1010 write the latched sum, AND and XOR value, respectively, to RAM[A]. Each latch keeps its value until the next operation of its own kind.
- R7: Opcode 4'b1011 loads field A into the program counter.
- R8: Opcode 4'b1100 jumps to A when the sum latch is zero, and to B otherwise.
- R9: Opcode 4'b1101 stops with return value A. Opcode 4'b1110 stops with return value RAM[A]. The halted flag and the return value are visible right after the executing edge.
- R10: In HALT, the program counter, the RAM and the return value do not change.
- R11: Synchronous reset clears the program counter, all three latches, the return value and the halted flag. It leaves the RAM and the instruction store untouched.
- R12: A cycle with the load enable high writes the load word into the instruction store at the load address, in any state, and executes no instruction in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Instruction store write enable |
| ld_addr | input | 5 | Instruction store write address |
| ld_word | input | 14 | Instruction word to write |
| halted | output | 1 | High in HALT |
| ret_val | output | 5 | Return value of the last exit |

## Verification
The bench keeps a behavioural model of the core and steps it on every rising edge. Every register-driven result (`halted`, `ret_val`, and, indirectly, the RAM) is due on the very edge that executes the instruction. The bench therefore samples at the falling edge that follows and compares against the model.

The programs are checked end to end: each one ends in an exit that exposes a RAM word or a branch outcome. Known totals are compared against hand-computed values, and the cycle of the halt is pinned down. A load-stall case pins halting to the exact cycle: each stalled cycle pushes the halt back by one edge, and the bench checks the flag on either side of that edge.

// File: rtl/tiny5_pkg.sv
package tiny5_pkg;
    localparam int OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_IDLE0     = 4'd0,
        OP_PUT       = 4'd1,
        OP_SAVE_SUM  = 4'd2,
        OP_SUM_I     = 4'd3,
        OP_SUM_M     = 4'd4,
        OP_CONJ_I    = 4'd5,
        OP_CONJ_M    = 4'd6,
        OP_DIFF_I    = 4'd7,
        OP_DIFF_M    = 4'd8,
        OP_SAVE_CONJ = 4'd9,
        OP_SAVE_DIFF = 4'd10,
        OP_GO        = 4'd11,
        OP_FORK      = 4'd12,
        OP_EXIT_I    = 4'd13,
        OP_EXIT_M    = 4'd14,
        OP_IDLE1     = 4'd15
    } op_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } st_e;
endpackage

// File: rtl/tiny5_imem.sv
module tiny5_imem #(
    parameter int AW = 5,
    parameter int IW = 14
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [IW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [IW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [IW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/tiny5_dram.sv
module tiny5_dram #(
    parameter int AW = 5,
    parameter int DW = 5
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_a,
    output logic [DW-1:0] rdata_b
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            words[waddr] <= wdata;
        end
    end

    assign rdata_a = words[raddr_a];
    assign rdata_b = words[raddr_b];
endmodule

// File: rtl/tiny5_alu.sv
module tiny5_alu #(
    parameter int DW = 5
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] sum,
    output logic [DW-1:0] conj,
    output logic [DW-1:0] diff
);
    always_comb begin
        sum  = a + b;
        conj = a & b;
        diff = a ^ b;
    end
endmodule

// File: rtl/tiny5_cpu.sv
module tiny5_cpu
    import tiny5_pkg::*;
#(
    parameter int FW = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ld_en,
    input  logic [FW-1:0]        ld_addr,
    input  logic [OPW+2*FW-1:0]  ld_word,
    output logic                 halted,
    output logic [FW-1:0]        ret_val
);
    localparam int IW = OPW + 2 * FW;

    st_e           state_q, state_d;
    logic [FW-1:0] pc_q, pc_d;
    logic [FW-1:0] sum_q, sum_d, conj_q, conj_d, diff_q, diff_d;
    logic [FW-1:0] ret_q, ret_d;

    logic [IW-1:0] instr;
    op_e           op;
    logic [FW-1:0] fld_a, fld_b;
    logic [FW-1:0] ram_a, ram_b;
    logic          ram_we;
    logic [FW-1:0] ram_waddr, ram_wdata;
    logic          use_mem;
    logic [FW-1:0] opnd_a, opnd_b;
    logic [FW-1:0] alu_sum, alu_conj, alu_diff;
    logic          run_now;

    tiny5_imem #(.AW(FW), .IW(IW)) imem_i (
        .clk   (clk),
        .we    (ld_en),
        .waddr (ld_addr),
        .wdata (ld_word),
        .raddr (pc_q),
        .rdata (instr)
    );

    assign op    = op_e'(instr[IW-1 -: OPW]);
    assign fld_a = instr[2*FW-1 -: FW];
    assign fld_b = instr[FW-1:0];

    tiny5_dram #(.AW(FW), .DW(FW)) dram_i (
        .clk     (clk),
        .we      (ram_we),
        .waddr   (ram_waddr),
        .wdata   (ram_wdata),
        .raddr_a (fld_a),
        .raddr_b (fld_b),
        .rdata_a (ram_a),
        .rdata_b (ram_b)
    );

    assign use_mem = (op == OP_SUM_M) || (op == OP_CONJ_M) || (op == OP_DIFF_M);
    assign opnd_a  = use_mem ? ram_a : fld_a;
    assign opnd_b  = use_mem ? ram_b : fld_b;

    tiny5_alu #(.DW(FW)) alu_i (
        .a    (opnd_a),
        .b    (opnd_b),
        .sum  (alu_sum),
        .conj (alu_conj),
        .diff (alu_diff)
    );

    assign run_now = (state_q == ST_RUN) && !ld_en;

    always_comb begin
        state_d   = state_q;
        pc_d      = pc_q;
        sum_d     = sum_q;
        conj_d    = conj_q;
        diff_d    = diff_q;
        ret_d     = ret_q;
        ram_we    = 1'b0;
        ram_waddr = fld_a;
        ram_wdata = fld_a;
        if (run_now) begin
            pc_d = pc_q + 1'b1;
            unique case (op)
                OP_IDLE0, OP_IDLE1: begin
                end
                OP_PUT: begin
                    ram_we    = 1'b1;
                    ram_waddr = fld_b;
                    ram_wdata = fld_a;
                end
                OP_SUM_I, OP_SUM_M:   sum_d  = alu_sum;
                OP_CONJ_I, OP_CONJ_M: conj_d = alu_conj;
                OP_DIFF_I, OP_DIFF_M: diff_d = alu_diff;
                OP_SAVE_SUM: begin
                    ram_we    = 1'b1;
                    ram_wdata = sum_q;
                end
                OP_SAVE_CONJ: begin
                    ram_we    = 1'b1;
                    ram_wdata = conj_q;
                end
                OP_SAVE_DIFF: begin
                    ram_we    = 1'b1;
                    ram_wdata = diff_q;
                end
                OP_GO:   pc_d = fld_a;
                OP_FORK: pc_d = (sum_q == '0) ? fld_a : fld_b;
                OP_EXIT_I: begin
                    state_d = ST_HALT;
                    pc_d    = pc_q;
                    ret_d   = fld_a;
                end
                OP_EXIT_M: begin
                    state_d = ST_HALT;
                    pc_d    = pc_q;
                    ret_d   = ram_a;
                end
                default: begin
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath and output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            sum_q  <= '0;
            conj_q <= '0;
            diff_q <= '0;
            ret_q  <= '0;
        end else begin
            pc_q   <= pc_d;
            sum_q  <= sum_d;
            conj_q <= conj_d;
            diff_q <= diff_d;
            ret_q  <= ret_d;
        end
    end

    assign halted  = (state_q == ST_HALT);
    assign ret_val = ret_q;

    assert_halt_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HALT) |=> (state_q == ST_HALT) && $stable(pc_q) && $stable(ret_q));

    assert_no_ram_write_halted_R10: assert property (@(posedge clk) disable iff (rst)
        halted |-> !ram_we);

    assert_pc_step_R1: assert property (@(posedge clk) disable iff (rst)
        (run_now && (op == OP_IDLE0 || op == OP_IDLE1 || op == OP_PUT))
        |=> pc_q == FW'($past(pc_q) + 1'b1));

    assert_load_stall_R12: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> $stable(pc_q) && $stable(sum_q));

    assert_sum_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !(run_now && (op == OP_SUM_I || op == OP_SUM_M)) |=> $stable(sum_q));

    assert_fork_taken_R8: assert property (@(posedge clk) disable iff (rst)
        (run_now && op == OP_FORK && sum_q == '0) |=> pc_q == $past(fld_a));
endmodule

// File: tb/tiny5_cpu_tb_top.sv
`timescale 1ns/1ps
module tiny5_cpu_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic [4:0]  ld_addr = '0;
    logic [13:0] ld_word = '0;
    logic        halted;
    logic [4:0]  ret_val;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    string cur_req = "R11";

    int m_pc, m_sum, m_conj, m_diff, m_hlt, m_ret;
    int m_imem[32];
    int m_ram[32];
    logic [13:0] prog[32];

    always #2.5 clk = ~clk;

    tiny5_cpu dut_i (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr),
        .ld_word(ld_word), .halted(halted), .ret_val(ret_val)
    );

    function automatic logic [13:0] enc(int op, int a, int b);
        logic [3:0] o = op[3:0];
        logic [4:0] x = a[4:0];
        logic [4:0] y = b[4:0];
        return {o, x, y};
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        int w, op, a, b;
        if (ld_en) m_imem[ld_addr] = int'(ld_word);
        if (rst) begin
            m_pc = 0; m_sum = 0; m_conj = 0; m_diff = 0; m_hlt = 0; m_ret = 0;
        end else if (!ld_en && m_hlt == 0) begin
            w = m_imem[m_pc];
            op = (w >> 10) & 15; a = (w >> 5) & 31; b = w & 31;
            m_pc = (m_pc + 1) % 32;
            case (op)
                1:  m_ram[b] = a;
                2:  m_ram[a] = m_sum;
                3:  m_sum = (a + b) % 32;
                4:  m_sum = (m_ram[a] + m_ram[b]) % 32;
                5:  m_conj = a & b;
                6:  m_conj = m_ram[a] & m_ram[b];
                7:  m_diff = a ^ b;
                8:  m_diff = m_ram[a] ^ m_ram[b];
                9:  m_ram[a] = m_conj;
                10: m_ram[a] = m_diff;
                11: m_pc = a;
                12: m_pc = (m_sum == 0) ? a : b;
                13: begin m_hlt = 1; m_ret = a; m_pc = (m_pc + 31) % 32; end
                14: begin m_hlt = 1; m_ret = m_ram[a]; m_pc = (m_pc + 31) % 32; end
                default: ;
            endcase
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk({cur_req, " halted vs model"}, int'(halted), m_hlt);
        chk({cur_req, " ret_val vs model"}, int'(ret_val), m_ret);
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 32; i++) prog[i] = '0;
    endtask

    task automatic load_and_start();
        rst = 1'b1;
        for (int i = 0; i < 32; i++) begin
            ld_en = 1'b1; ld_addr = 5'(i); ld_word = prog[i];
            tick();
        end
        ld_en = 1'b0;
        tick();
        chk("R11 reset halted", int'(halted), 0);
        chk("R11 reset ret_val", int'(ret_val), 0);
        rst = 1'b0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  [TB] %0d tests run, %0d failed", checks + 1, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) begin m_imem[i] = 0; m_ram[i] = 0; end
        m_pc = 0; m_sum = 0; m_conj = 0; m_diff = 0; m_hlt = 0; m_ret = 0;
        @(negedge clk);

        // R2 R3 R9: put, two idles, exit from RAM; halts on the 4th edge
        cur_req = "R2";
        clear_prog();
        prog[0] = enc(1, 9, 4);
        prog[1] = enc(0, 3, 4);
        prog[2] = enc(15, 9, 4);
        prog[3] = enc(14, 4, 0);
        load_and_start();
        run(3);
        chk("R9 not yet halted", int'(halted), 0);
        run(1);
        chk("R9 halted after exit edge", int'(halted), 1);
        chk("R2 ret RAM[4]", int'(ret_val), 9);
        cur_req = "R10";
        run(6);
        chk("R10 ret held", int'(ret_val), 9);
        chk("R10 still halted", int'(halted), 1);

        // R4 R5 R6: immediate ops, sum wrap, stores, memory sum
        cur_req = "R4";
        clear_prog();
        prog[0] = enc(3, 20, 15);
        prog[1] = enc(7, 6, 3);
        prog[2] = enc(5, 28, 13);
        prog[3] = enc(2, 10, 0);
        prog[4] = enc(10, 11, 0);
        prog[5] = enc(9, 12, 0);
        prog[6] = enc(4, 10, 11);
        prog[7] = enc(2, 13, 0);
        prog[8] = enc(14, 13, 0);
        load_and_start();
        run(9);
        chk("R4 R5 sum of wrapped 3 and xor 5", int'(ret_val), 8);

        // R11 RAM kept across reset; R6 conj latch value 12 stored earlier
        cur_req = "R11";
        clear_prog();
        prog[0] = enc(14, 12, 0);
        load_and_start();
        run(1);
        chk("R6 stored AND 28&13", int'(ret_val), 12);
        clear_prog();
        prog[0] = enc(14, 10, 0);
        load_and_start();
        run(1);
        chk("R4 sum 20+15 wraps", int'(ret_val), 3);

        // R5: memory AND / XOR
        cur_req = "R5";
        clear_prog();
        prog[0] = enc(1, 22, 1);
        prog[1] = enc(1, 13, 2);
        prog[2] = enc(6, 1, 2);
        prog[3] = enc(8, 1, 2);
        prog[4] = enc(9, 5, 0);
        prog[5] = enc(10, 6, 0);
        prog[6] = enc(4, 5, 6);
        prog[7] = enc(2, 7, 0);
        prog[8] = enc(14, 7, 0);
        load_and_start();
        run(9);
        chk("R5 (22&13)+(22^13)", int'(ret_val), 31);
        clear_prog();
        prog[0] = enc(14, 6, 0);
        load_and_start();
        run(1);
        chk("R5 xor 22^13", int'(ret_val), 27);

        // R7 R8 R1: fork taken on zero, PC wraps 31->0, fork not taken, jump
        cur_req = "R8";
        clear_prog();
        prog[0]  = enc(12, 29, 5);
        prog[29] = enc(3, 1, 0);
        prog[30] = enc(0, 0, 0);
        prog[31] = enc(15, 0, 0);
        prog[5]  = enc(11, 9, 0);
        prog[6]  = enc(13, 3, 0);
        prog[9]  = enc(13, 21, 0);
        load_and_start();
        run(7);
        chk("R7 R8 R1 fork/wrap/jump path", int'(ret_val), 21);
        chk("R9 halted after immediate exit", int'(halted), 1);

        // R8: sum wraps to zero so fork takes field A
        clear_prog();
        prog[0] = enc(3, 17, 15);
        prog[1] = enc(12, 4, 3);
        prog[3] = enc(13, 1, 0);
        prog[4] = enc(13, 2, 0);
        load_and_start();
        run(3);
        chk("R8 zero sum takes A", int'(ret_val), 2);

        // R10: instruction after exit never writes RAM
        cur_req = "R10";
        clear_prog();
        prog[0] = enc(1, 3, 20);
        prog[1] = enc(13, 0, 0);
        prog[2] = enc(1, 30, 20);
        load_and_start();
        run(8);
        clear_prog();
        prog[0] = enc(14, 20, 0);
        load_and_start();
        run(1);
        chk("R10 RAM unchanged after halt", int'(ret_val), 3);

        // R12: load during run stalls and rewrites a later instruction
        cur_req = "R12";
        clear_prog();
        prog[2] = enc(13, 7, 0);
        load_and_start();
        run(1);
        ld_en = 1'b1; ld_addr = 5'd2; ld_word = enc(13, 25, 0);
        run(2);
        ld_en = 1'b0;
        run(1);
        chk("R12 stall delays halt", int'(halted), 0);
        run(1);
        chk("R12 halted after stalls", int'(halted), 1);
        chk("R12 loaded word executed", int'(ret_val), 25);

        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule